// File: doc/BRIEF.md
# PHY Control-Register Write Sequencer

This block carries out a single register write into a high-speed serial PHY through its slow parallel control port. The user side offers a 16-bit address and a 16-bit value together with a one-cycle start request. The block then toggles a port clock that it generates itself and walks through a fixed series of steps. First, with the select line high, it emits a burst of warm-up clock pulses. Next it drops select, puts the value on the write-data bus and raises write enable. Finally it drives the address and raises select and the port clock together. From then on it checks the acknowledge input at the end of every high level of the port clock.

An acknowledge ends the transfer at once with a done pulse. When no acknowledge arrives within a bounded number of clock pulses, the block ends the transfer with an error pulse. It never waits indefinitely. Each level of the port clock is held for a programmable number of system-clock cycles, so the port runs far slower than the system clock and meets the PHY's minimum level time. A start request seen while a transfer is running has no effect.

Top module: `phy_cr_writer`

## Requirements
- R1: After reset, busy, done, error, the port clock, select and write enable are all 0, and the port address and write-data buses are 0.
- R2: Before write enable rises, select is held high while exactly PRE_PULSES (default 15) full port-clock pulses are issued, each a high level followed by a low level.
- R3: Every high level of the port clock lasts exactly HOLD_CYC system-clock cycles. No low level inside a transfer is shorter than HOLD_CYC cycles.
- R4: When the warm-up burst ends, select goes low, the latched value appears on the write-data bus and write enable goes high, all in the same cycle, while the port clock is low.
- R5: After a further HOLD_CYC cycles, the latched address is driven and the port clock and select rise in the same cycle.
- R6: The acknowledge input is sampled in the last cycle of each high level of the address phase. If it is high, the port clock falls and done pulses on the next edge. Counting from the edge that accepts start, done arrives HOLD_CYC*(31+2n) cycles later when the acknowledge is first seen on attempt n.
- R7: After an attempt with no acknowledge, the port clock goes low for HOLD_CYC cycles and rises again for the next attempt. When attempt MAX_TRIES (default 10) also sees no acknowledge, error pulses HOLD_CYC*51 cycles after the start edge, with the default counts.
- R8: busy is high from the edge that accepts start until the edge that raises done or error. done and error each last one cycle and never occur together.
- R9: A start request while busy is high changes neither the address nor the value that is written, nor the timing of the transfer, and it queues no second transfer.
- R10: At the end of a transfer, whether it succeeded or failed, write enable, select and the port clock are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request one write; accepted only when not busy |
| addr | input | 16 | PHY register address, latched on start |
| data | input | 16 | Value to write, latched on start |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse: write acknowledged |
| error | output | 1 | One-cycle pulse: no acknowledge within the retry limit |
| cr_clk | output | 1 | Generated port clock |
| cr_sel | output | 1 | Port select |
| cr_addr | output | 16 | Port address bus |
| cr_wdata | output | 16 | Port write-data bus |
| cr_wen | output | 1 | Port write enable |
| cr_ack | input | 1 | Acknowledge from the PHY |

## Verification
The embedded assertions check, on every cycle, the following: that the port clock changes only when the level timer has expired; that select accompanies every port-clock rise in the address phase; that done and error are single, exclusive pulses; that write enable and the clock rest low while idle; that the latched address stays fixed during a transfer; and that neither counter wraps. The bench scenarios are the only place where the exact warm-up pulse count, the bus contents at the write-enable and address edges, and the end-to-end latency can be seen. The bench sweeps the acknowledge delay across every attempt number, including the delays that produce an error. It also shows that a start request arriving mid-transfer neither alters the write nor queues another one.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

  typedef enum logic [2:0] {
    CR_IDLE   = 3'd0,
    CR_SEL    = 3'd1,
    CR_PRE_HI = 3'd2,
    CR_PRE_LO = 3'd3,
    CR_SETUP  = 3'd4,
    CR_ACK_HI = 3'd5,
    CR_ACK_LO = 3'd6
  } cr_state_e;

endpackage

// File: rtl/phy_cr_rst_sync.sv
module phy_cr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/phy_cr_hold_timer.sv
module phy_cr_hold_timer #(
  parameter int HOLD_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? W'(HOLD_CYC - 1) : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R3: the level timer never holds more than HOLD_CYC-1 remaining cycles
  assert_timer_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W'(HOLD_CYC - 1));
endmodule

// File: rtl/phy_cr_evt_cnt.sv
module phy_cr_evt_cnt #(
  parameter int MAX = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic full
);
  localparam int W = $clog2(MAX + 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = clr ? '0 : (cnt_q + W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign full = (cnt_q == W'(MAX));

  // R2 / R7: pulse and attempt counters never step past their limit
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !full);
endmodule

// File: rtl/phy_cr_writer.sv
module phy_cr_writer #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int PRE_PULSES = 15,
  parameter int MAX_TRIES  = 10,
  parameter int HOLD_CYC   = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              cr_clk,
  output logic              cr_sel,
  output logic [ADDR_W-1:0] cr_addr,
  output logic [DATA_W-1:0] cr_wdata,
  output logic              cr_wen,
  input  logic              cr_ack
);
  import phy_cr_pkg::*;

  logic rst_n_s;

  phy_cr_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  cr_state_e         st_q, st_d;
  logic              clk_d, sel_d, wen_d, busy_d, done_d, err_d;
  logic [ADDR_W-1:0] addr_q, caddr_d;
  logic [DATA_W-1:0] data_q, wdata_d;
  logic              cap_en, caddr_en, wdata_en;
  logic              tmr_load, tmr_exp;
  logic              pre_inc, pre_full, try_inc, try_full, cnt_clr;

  phy_cr_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (tmr_load),
    .expired (tmr_exp)
  );

  phy_cr_evt_cnt #(.MAX(PRE_PULSES)) u_pre_cnt (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (cnt_clr),
    .inc   (pre_inc),
    .full  (pre_full)
  );

  phy_cr_evt_cnt #(.MAX(MAX_TRIES)) u_try_cnt (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (cnt_clr),
    .inc   (try_inc),
    .full  (try_full)
  );

  // next-state and output decode
  always_comb begin
    st_d     = st_q;
    clk_d    = cr_clk;
    sel_d    = cr_sel;
    wen_d    = cr_wen;
    busy_d   = busy;
    done_d   = 1'b0;
    err_d    = 1'b0;
    caddr_d  = addr_q;
    wdata_d  = data_q;
    cap_en   = 1'b0;
    caddr_en = 1'b0;
    wdata_en = 1'b0;
    tmr_load = 1'b0;
    pre_inc  = 1'b0;
    try_inc  = 1'b0;
    cnt_clr  = 1'b0;
    case (st_q)
      CR_IDLE: begin
        if (start) begin
          st_d     = CR_SEL;
          sel_d    = 1'b1;
          busy_d   = 1'b1;
          cap_en   = 1'b1;
          cnt_clr  = 1'b1;
          tmr_load = 1'b1;
        end
      end
      CR_SEL: begin
        if (tmr_exp) begin
          st_d     = CR_PRE_HI;
          clk_d    = 1'b1;
          tmr_load = 1'b1;
        end
      end
      CR_PRE_HI: begin
        if (tmr_exp) begin
          st_d     = CR_PRE_LO;
          clk_d    = 1'b0;
          pre_inc  = 1'b1;
          tmr_load = 1'b1;
        end
      end
      CR_PRE_LO: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (pre_full) begin
            st_d     = CR_SETUP;
            sel_d    = 1'b0;
            wen_d    = 1'b1;
            wdata_en = 1'b1;
          end else begin
            st_d  = CR_PRE_HI;
            clk_d = 1'b1;
          end
        end
      end
      CR_SETUP: begin
        if (tmr_exp) begin
          st_d     = CR_ACK_HI;
          caddr_en = 1'b1;
          clk_d    = 1'b1;
          sel_d    = 1'b1;
          try_inc  = 1'b1;
          tmr_load = 1'b1;
        end
      end
      CR_ACK_HI: begin
        if (tmr_exp) begin
          clk_d = 1'b0;
          if (cr_ack || try_full) begin
            st_d   = CR_IDLE;
            wen_d  = 1'b0;
            sel_d  = 1'b0;
            busy_d = 1'b0;
            done_d = cr_ack;
            err_d  = !cr_ack;
          end else begin
            st_d     = CR_ACK_LO;
            tmr_load = 1'b1;
          end
        end
      end
      CR_ACK_LO: begin
        if (tmr_exp) begin
          st_d     = CR_ACK_HI;
          clk_d    = 1'b1;
          try_inc  = 1'b1;
          tmr_load = 1'b1;
        end
      end
      default: begin
        st_d   = CR_IDLE;
        clk_d  = 1'b0;
        sel_d  = 1'b0;
        wen_d  = 1'b0;
        busy_d = 1'b0;
      end
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= CR_IDLE;
      cr_clk <= 1'b0;
      cr_sel <= 1'b0;
      cr_wen <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cr_clk <= clk_d;
      cr_sel <= sel_d;
      cr_wen <= wen_d;
      busy   <= busy_d;
      done   <= done_d;
      error  <= err_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q   <= '0;
      data_q   <= '0;
      cr_addr  <= '0;
      cr_wdata <= '0;
    end else begin
      if (cap_en) begin
        addr_q <= addr;
        data_q <= data;
      end
      if (caddr_en) cr_addr  <= caddr_d;
      if (wdata_en) cr_wdata <= wdata_d;
    end
  end

  // R8: completion pulses are exclusive and last one cycle
  assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(done && error));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    error |=> !error);
  // R10: idle port rests with write enable and clock low
  assert_idle_rest_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> (!cr_wen && !cr_clk));
  // R3: the port clock moves only after its level timer has run out
  assert_level_hold_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cr_clk != $past(cr_clk)) |-> $past(tmr_exp));
  // R5: every address-phase rise of the port clock carries select
  assert_sel_with_clk_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($rose(cr_clk) && cr_wen) |-> cr_sel);
  // R9: latched address stays fixed while a transfer runs
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && $past(busy)) |-> $stable(addr_q));
endmodule

// File: tb/phy_cr_writer_bench.sv
module phy_cr_writer_bench;
  localparam int H   = 3;
  localparam int PRE = 15;
  localparam int MT  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] data = '0;
  logic        busy, done, error;
  logic        cr_clk, cr_sel, cr_wen;
  logic [15:0] cr_addr, cr_wdata;
  logic        cr_ack;

  int tests = 0, fails = 0;
  int mon_tests = 0, mon_fails = 0;
  int cyc = 0;
  int k_cfg = 0;
  logic [15:0] exp_addr = '0, exp_data = '0;

  always #4 clk = ~clk;

  phy_cr_writer #(.PRE_PULSES(PRE), .MAX_TRIES(MT), .HOLD_CYC(H)) u_phy_cr_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .data(data),
    .busy(busy), .done(done), .error(error),
    .cr_clk(cr_clk), .cr_sel(cr_sel), .cr_addr(cr_addr), .cr_wdata(cr_wdata),
    .cr_wen(cr_wen), .cr_ack(cr_ack)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor and responder, sampled at negedge
  logic prev_clk = 1'b0, prev_wen = 1'b0, prev_busy = 1'b0;
  int hi_run = 0, lo_run = 0, pre_rises = 0, ack_edges = 0, txn_cnt = 0, rises = 0;

  assign cr_ack = cr_wen && (ack_edges >= k_cfg);

  always @(negedge clk) begin
    if (busy && !prev_busy) txn_cnt = txn_cnt + 1;
    if (!busy) begin pre_rises = 0; ack_edges = 0; rises = 0; end
    if (cr_clk && !prev_clk) begin
      if (rises > 0) begin
        mon_tests++;
        if (lo_run < H) begin
          mon_fails++;
          $display("FAIL R3 low level act=%0d exp>=%0d", lo_run, H);
        end
      end
      rises = rises + 1;
      if (cr_sel && !cr_wen) pre_rises = pre_rises + 1;
      if (cr_wen) begin
        if (ack_edges == 0) begin
          mon_tests++;
          if (cr_addr !== exp_addr || cr_sel !== 1'b1) begin
            mon_fails++;
            $display("FAIL R5 addr act=%h sel=%b exp=%h sel=1", cr_addr, cr_sel, exp_addr);
          end
        end
        ack_edges = ack_edges + 1;
      end
    end
    if (!cr_clk && prev_clk) begin
      mon_tests++;
      if (hi_run != H) begin
        mon_fails++;
        $display("FAIL R3 high level act=%0d exp=%0d", hi_run, H);
      end
    end
    if (cr_wen && !prev_wen) begin
      mon_tests++;
      if (pre_rises != PRE) begin
        mon_fails++;
        $display("FAIL R2 pre pulses act=%0d exp=%0d", pre_rises, PRE);
      end
      mon_tests++;
      if (cr_sel !== 1'b0 || cr_clk !== 1'b0 || cr_wdata !== exp_data) begin
        mon_fails++;
        $display("FAIL R4 sel=%b clk=%b wdata=%h exp sel=0 clk=0 wdata=%h",
                 cr_sel, cr_clk, cr_wdata, exp_data);
      end
    end
    if (cr_clk) begin hi_run = (cr_clk == prev_clk) ? hi_run + 1 : 1; lo_run = 0; end
    else        begin lo_run = (cr_clk == prev_clk) ? lo_run + 1 : 1; hi_run = 0; end
    prev_clk  = cr_clk;
    prev_wen  = cr_wen;
    prev_busy = busy;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run_wr(input logic [15:0] a, input logic [15:0] d, input int k, input bit inject);
    int e0, n, lat, exp_lat, txn0;
    bit got_done, got_err;
    k_cfg = k; exp_addr = a; exp_data = d;
    n = (k == 0) ? 1 : k;
    txn0 = txn_cnt;
    @(negedge clk);
    start = 1'b1; addr = a; data = d;
    e0 = cyc + 1;
    @(negedge clk);
    start = 1'b0; addr = ~a; data = ~d;
    chk(busy === 1'b1, "R8 busy after start", busy, 1);
    got_done = 0; got_err = 0;
    for (int i = 0; i < 2000; i++) begin
      if (inject && i == 20) begin start = 1'b1; addr = a ^ 16'h5a5a; data = d ^ 16'h0ff0; end
      if (inject && i == 21) start = 1'b0;
      if (done || error) begin got_done = done; got_err = error; break; end
      @(negedge clk);
    end
    start = 1'b0;
    lat = cyc - e0;
    if (n <= MT) begin
      exp_lat = H * (31 + 2 * n);
      chk(got_done && !got_err, "R6 done raised", got_done, 1);
      chk(lat == exp_lat, "R6 latency", lat, exp_lat);
    end else begin
      exp_lat = H * 51;
      chk(got_err && !got_done, "R7 error raised", got_err, 1);
      chk(lat == exp_lat, "R7 error latency", lat, exp_lat);
    end
    chk(busy === 1'b0, "R8 busy cleared at end", busy, 0);
    chk(cr_wen === 1'b0 && cr_clk === 1'b0 && cr_sel === 1'b0, "R10 rest state",
        {cr_wen, cr_clk, cr_sel}, 0);
    @(negedge clk);
    chk(done === 1'b0 && error === 1'b0, "R8 single-cycle pulse", {done, error}, 0);
    repeat (4) @(negedge clk);
    chk(txn_cnt == txn0 + 1 && busy === 1'b0, "R9 one transfer only", txn_cnt - txn0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, error, cr_clk, cr_sel, cr_wen} === 6'b0, "R1 reset controls",
        {busy, done, error, cr_clk, cr_sel, cr_wen}, 0);
    chk(cr_addr === 16'h0 && cr_wdata === 16'h0, "R1 reset buses", cr_addr, 0);
    for (int k = 0; k <= MT + 2; k++)
      run_wr(16'h0022 + 16'(k * 16'h1111), 16'h00f5 ^ 16'(k * 16'h0203), k, 1'b0);
    run_wr(16'hffff, 16'h0000, 4, 1'b1);   // R9 start during transfer
    run_wr(16'h0000, 16'hffff, MT, 1'b1);  // R9 near the retry boundary
    run_wr(16'ha5c3, 16'h3c5a, MT + 1, 1'b1);
    tests += mon_tests;
    fails += mon_fails;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    $display("FAIL watchdog expired act=hang exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests + mon_tests + 1, fails + mon_fails + 1);
    $finish;
  end
endmodule